// File: doc/BRIEF.md
# Dual-Mode Serial Register Port

This block is the slave side of a slow serial control link. It gives an external controller access to a bank of 32 eight-bit registers. The controller lowers a chip select and clocks one 16-bit command frame through a serial clock and data input. The frame holds a chip address, a direction flag, a register address and a data byte. Write frames update one register. In read/write mode, read frames return the addressed register on a serial data output. That output has a separate drive enable, so it can be tri-stated.

Every serial input is sampled by the system clock through a two-stage synchroniser. Serial clock edges are then detected in that domain, so the whole block runs on a single clock. A mode input switches the port to write-only operation, in which the output is never driven. An active-low power-down input returns every register to its default value. Writes are held off while the power-down input is asserted and while a watchdog on the master clock input reports that clock as absent.

Top module: `serial_reg_port`

## Requirements
- R1: A frame is, first bit first: a 2-bit chip address, a direction bit (1 = write, 0 = read), a 5-bit register address MSB first, then 8 data bits MSB first. A frame whose chip address is not 2'b11 writes nothing and never asserts `sdo_oe`.
- R2: Frame bits are taken from `sdi` on rising edges of `sclk` while `cs_n` is low. Read data on `sdo` changes only after falling edges of `sclk`.
- R3: A write commits on the 16th rising `sclk` edge after `cs_n` falls. If `cs_n` rises before that edge, no register changes. Edges beyond the 16th are ignored until `cs_n` has been high.
- R4: With `mode_3w` = 0, a read frame drives the addressed register onto `sdo`, MSB first. The first bit appears after the falling edge that follows the 8th rising edge, and a new bit follows each falling edge through the one after the 15th rising edge. `sdo_oe` is high from that first falling edge until `cs_n` rises. `sdo_oe` stays low during write frames.
- R5: `sdo_oe` is low whenever `cs_n` has been high for 3 or more `clk` cycles. `sdo` reads 0 whenever `sdo_oe` is low.
- R6: With `mode_3w` = 1, write frames work as in R3, read frames have no effect, and `sdo_oe` stays low.
- R7: While `pdn_n` is low, register i holds its default value, `((8*i) mod 256) XOR 8'h5A`.
- R8: The master clock counts as absent from power-down release until its first edge, and again after `MCLK_LIMIT` consecutive `clk` cycles with no edge on `mclk`. While it is absent, write frames change no register.
- R9: `regs_flat[8*i+7:8*i]` always shows register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is clocked by it |
| pdn_n | input | 1 | Active-low power-down and asynchronous reset |
| mclk | input | 1 | Master clock watched for presence |
| mode_3w | input | 1 | 0 = read/write port, 1 = write-only port |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial bit clock |
| sdi | input | 1 | Serial command and data input |
| sdo | output | 1 | Serial read data |
| sdo_oe | output | 1 | Drive enable for `sdo`; low means high impedance |
| regs_flat | output | 256 | Contents of all 32 registers, register i at bits 8*i+7:8*i |

## Verification
Two functions can land in the same cycle: a write commit on the 16th rising edge, and a power-down that clears the bank. The bench provokes this with a write frame whose `pdn_n` falls two `clk` cycles after the 16th rising `sclk` edge, while the synchronised edge is still in flight. After release it requires every register to show its default value, so a write that survived the reset, or landed just after it, is reported. Stopping `mclk` just before a write frame exercises the watchdog interplay in the same way; that frame must leave the bank untouched.

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
  parameter int AW = 5,
  parameter int DW = 8,
  parameter int MCLK_LIMIT = 64,
  parameter logic [1:0] CHIP_ID = 2'b11,
  parameter logic [DW-1:0] DEF_XOR = 8'h5A
) (
  input  logic clk,
  input  logic pdn_n,
  input  logic mclk,
  input  logic mode_3w,
  input  logic cs_n,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_oe,
  output logic [(1<<AW)*DW-1:0] regs_flat
);
  localparam int NREG = 1 << AW;
  localparam int HW = 3 + AW;
  localparam int FW = HW + DW;
  localparam int CW = $clog2(FW + 1);
  localparam int MW = $clog2(MCLK_LIMIT + 1);

  function automatic logic [DW-1:0] dflt(input int i);
    return DW'(i * 8) ^ DEF_XOR;
  endfunction

  logic [1:0] cs_q, sdi_q;
  logic [2:0] sck_q, mck_q;
  logic [FW-2:0] sh;
  logic [CW-1:0] bitcnt;
  logic [MW-1:0] mcnt;
  logic [DW-1:0] rsh;
  logic rd_act, oe_q, sdo_q;
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk or negedge pdn_n)
    if (!pdn_n) begin
      cs_q  <= 2'b11;
      sdi_q <= '0;
      sck_q <= '0;
      mck_q <= '0;
    end else begin
      cs_q  <= {cs_q[0], cs_n};
      sdi_q <= {sdi_q[0], sdi};
      sck_q <= {sck_q[1:0], sclk};
      mck_q <= {mck_q[1:0], mclk};
    end

  wire cs_s     = cs_q[1];
  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire mck_edge = mck_q[1] ^ mck_q[2];
  wire [FW-1:0] word = {sh, sdi_q[1]};

  always_ff @(posedge clk or negedge pdn_n)
    if (!pdn_n) mcnt <= MW'(MCLK_LIMIT);
    else if (mck_edge) mcnt <= '0;
    else if (mcnt != MW'(MCLK_LIMIT)) mcnt <= mcnt + 1'b1;

  wire mclk_ok = (mcnt != MW'(MCLK_LIMIT));

  wire hdr_rd = (word[HW-1 -: 2] == CHIP_ID) && !word[AW] && !mode_3w;
  wire wr_en  = !cs_s && sck_rise && (bitcnt == CW'(FW-1)) &&
                (word[FW-1 -: 2] == CHIP_ID) && word[DW+AW] && mclk_ok;

  always_ff @(posedge clk or negedge pdn_n)
    if (!pdn_n) begin
      sh     <= '0;
      bitcnt <= '0;
      rd_act <= 1'b0;
      oe_q   <= 1'b0;
      sdo_q  <= 1'b0;
      rsh    <= '0;
    end else if (cs_s) begin
      bitcnt <= '0;
      rd_act <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      if (sck_rise && bitcnt != CW'(FW)) begin
        sh     <= word[FW-2:0];
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == CW'(HW-1) && hdr_rd) begin
          rd_act <= 1'b1;
          rsh    <= regs[word[AW-1:0]];
        end
      end
      if (sck_fall && rd_act && bitcnt >= CW'(HW) && bitcnt < CW'(FW)) begin
        sdo_q <= rsh[DW-1];
        rsh   <= {rsh[DW-2:0], 1'b0};
        oe_q  <= 1'b1;
      end
      if (mode_3w) begin
        rd_act <= 1'b0;
        oe_q   <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge pdn_n)
    if (!pdn_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= dflt(i);
    end else if (wr_en) begin
      regs[word[DW +: AW]] <= word[DW-1:0];
    end

  assign sdo_oe = oe_q;
  assign sdo    = oe_q & sdo_q;

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[g*DW +: DW] = regs[g];
  end
endmodule

module serial_reg_port_chk #(
  parameter int NB = 256,
  parameter int CW = 5,
  parameter int HW = 8,
  parameter int FW = 16
) (
  input logic clk,
  input logic pdn_n,
  input logic mode_3w,
  input logic cs_s,
  input logic sck_rise,
  input logic mclk_ok,
  input logic sdo_oe,
  input logic [CW-1:0] bitcnt,
  input logic [NB-1:0] regs_flat
);
  p_commit_edge_r3: assert property (@(posedge clk) disable iff (!pdn_n)
    !$stable(regs_flat) |-> $past(sck_rise) && $past(bitcnt) == CW'(FW-1));
  p_bitcnt_bound_r3: assert property (@(posedge clk) disable iff (!pdn_n)
    bitcnt <= CW'(FW));
  p_commit_clock_r8: assert property (@(posedge clk) disable iff (!pdn_n)
    !$stable(regs_flat) |-> $past(mclk_ok));
  p_oe_start_r4: assert property (@(posedge clk) disable iff (!pdn_n)
    $rose(sdo_oe) |-> bitcnt == CW'(HW));
  p_oe_release_r5: assert property (@(posedge clk) disable iff (!pdn_n)
    cs_s |=> !sdo_oe);
  p_oe_mode_r6: assert property (@(posedge clk) disable iff (!pdn_n)
    $rose(sdo_oe) |-> !$past(mode_3w));
endmodule

bind serial_reg_port serial_reg_port_chk #(
  .NB(NREG*DW), .CW(CW), .HW(HW), .FW(FW)
) u_chk (
  .clk(clk), .pdn_n(pdn_n), .mode_3w(mode_3w), .cs_s(cs_s),
  .sck_rise(sck_rise), .mclk_ok(mclk_ok), .sdo_oe(sdo_oe),
  .bitcnt(bitcnt), .regs_flat(regs_flat)
);

// File: tb/serial_reg_port_test.sv
module serial_reg_port_test;
  localparam int H = 6;
  localparam int LIM = 32;

  logic clk = 0, pdn_n = 0, mclk = 0, mode_3w = 0, cs_n = 1, sclk = 0, sdi = 0;
  logic sdo, sdo_oe;
  logic [255:0] regs_flat;
  logic [7:0] model [32];
  bit mclk_on = 1;
  int total = 0, bad = 0;
  bit done = 0;

  serial_reg_port #(.MCLK_LIMIT(LIM)) uut (
    .clk(clk), .pdn_n(pdn_n), .mclk(mclk), .mode_3w(mode_3w), .cs_n(cs_n),
    .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe), .regs_flat(regs_flat)
  );

  always #5 clk = ~clk;

  initial forever begin
    repeat (3) @(negedge clk);
    if (mclk_on) mclk = ~mclk;
  end

  function automatic logic [7:0] dflt(input int i);
    return 8'(i * 8) ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_bank(input string req);
    logic [255:0] e;
    for (int i = 0; i < 32; i++) e[i*8 +: 8] = model[i];
    total++;
    if (regs_flat !== e) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, regs_flat, e);
    end
  endtask

  task automatic load_defaults();
    for (int i = 0; i < 32; i++) model[i] = dflt(i);
  endtask

  task automatic set_mclk(input bit on);
    mclk_on = on;
    repeat (3 * LIM) @(negedge clk);
  endtask

  task automatic frame(input logic [1:0] chip, input bit rw, input logic [4:0] a,
                       input logic [7:0] d, input int nbits, input bit pd_end);
    logic [15:0] w;
    bit exp_rd;
    w = {chip, rw, a, d};
    exp_rd = (chip == 2'b11) && !rw && !mode_3w;
    @(negedge clk) cs_n = 0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = w[15-i];
      repeat (H) @(negedge clk);
      if (i >= 8) begin
        if (exp_rd) chk("R2 R4", {30'd0, sdo_oe, sdo}, {30'd0, 1'b1, model[a][15-i]});
        else if (chip != 2'b11) chk("R1", {31'd0, sdo_oe}, 0);
        else if (mode_3w) chk("R6", {31'd0, sdo_oe}, 0);
        else chk("R4", {31'd0, sdo_oe}, 0);
      end
      sclk = 1;
      if (pd_end && i == 15) begin
        repeat (2) @(negedge clk);
        pdn_n = 0;
        repeat (H - 2) @(negedge clk);
      end else repeat (H) @(negedge clk);
      sclk = 0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1;
    repeat (4) @(negedge clk);
    chk("R5", {31'd0, sdo_oe}, 0);
    chk("R5", {31'd0, sdo}, 0);
    if (pd_end) begin
      pdn_n = 1;
      load_defaults();
      repeat (20) @(negedge clk);
    end else if (nbits == 16 && chip == 2'b11 && rw && mclk_on) model[a] = d;
  endtask

  initial begin
    load_defaults();
    repeat (5) @(negedge clk);
    chk("R7", {31'd0, sdo_oe}, 0);
    chk_bank("R7 R9");
    pdn_n = 1;
    repeat (20) @(negedge clk);
    chk_bank("R7");

    frame(2'b11, 1, 5'd5, 8'hC3, 16, 0);  chk_bank("R2 R3");
    frame(2'b11, 0, 5'd5, 8'h00, 16, 0);
    frame(2'b11, 0, 5'd31, 8'h00, 16, 0);
    frame(2'b11, 0, 5'd0, 8'h00, 16, 0);
    frame(2'b10, 1, 5'd5, 8'hFF, 16, 0);  chk_bank("R1");
    frame(2'b01, 0, 5'd5, 8'h00, 16, 0);
    frame(2'b11, 1, 5'd7, 8'h99, 12, 0);  chk_bank("R3");
    frame(2'b11, 1, 5'd7, 8'h99, 15, 0);  chk_bank("R3");
    mode_3w = 1;
    frame(2'b11, 1, 5'd9, 8'h3C, 16, 0);  chk_bank("R6");
    frame(2'b11, 0, 5'd9, 8'h00, 16, 0);
    mode_3w = 0;
    frame(2'b11, 0, 5'd9, 8'h00, 16, 0);
    set_mclk(0);
    frame(2'b11, 1, 5'd5, 8'h11, 16, 0);  chk_bank("R8");
    set_mclk(1);
    frame(2'b11, 1, 5'd5, 8'h22, 16, 0);  chk_bank("R8");
    frame(2'b11, 1, 5'd12, 8'hA7, 16, 1); chk_bank("R7");
    frame(2'b11, 1, 5'd12, 8'hA7, 16, 0); chk_bank("R3");
    @(negedge clk) pdn_n = 0;
    repeat (3) @(negedge clk);
    load_defaults();
    chk_bank("R7");
    pdn_n = 1;
    repeat (20) @(negedge clk);

    void'($urandom(32'd2024));
    for (int k = 0; k < 250; k++) begin
      logic [1:0] c;
      int nb;
      c  = ($urandom % 8 == 0) ? 2'($urandom) : 2'b11;
      nb = ($urandom % 8 == 0) ? 1 + int'($urandom % 15) : 16;
      mode_3w = ($urandom % 4 == 0);
      if ($urandom % 16 == 0) set_mclk(!mclk_on);
      frame(c, 1'($urandom), 5'($urandom), 8'($urandom), nb, 0);
      chk_bank("R1 R3 R6 R8");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(negedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule